// File: doc/BRIEF.md
# Bubble Sensor Self-Test and Safety Supervisor

This block supervises an ultrasonic bubble sensor whose readings reach it through an upstream classifier. When the supervisor is enabled, it first proves that the sensor works. It raises the sensor's test line, which should make the classifier report a bubble. It then lowers the test line and expects the classifier to report a clear line again. Each of the two phases has its own timeout, counted on a 1 ms tick input.

After a passed self-test the supervisor watches the classifier. The first bubble it sees latches a safe-state output to the host equipment. A failed self-test also drives the safe-state output and raises a fail flag. Dropping the enable input returns the block to idle and clears the pass and fail flags. The safe-state latch survives that. Only a reset or a new successful self-test clears it.

The classifier reports through a valid strobe and a bubble flag. The supervisor keeps the most recent classification between strobes.

Top module: `bubble_guard_top`

## Requirements
- R1: After reset, testLine, passOk, failSt and safeTrip are 0. The enable input counts as having been high before reset, so an enable that is already high when reset releases does not start a test until it has been sampled low.
- R2: At the first clock edge that samples enable high after an edge that sampled it low, the self-test starts and testLine goes to 1 at that edge.
- R3: The bubble flag is taken only at edges where clsValid is 1. At other edges the held classification is kept, and a changing clsBubble has no effect on the outputs.
- R4: While testLine is 1, a held bubble classification ends the force phase and testLine returns to 0 at the next edge. This takes priority over an expired timer at the same edge.
- R5: The force phase loads a timeout of TIMEOUT_MS (default 500). Each msTick pulse decrements it by one. If it reaches zero without a held bubble, the next edge enters the failed state.
- R6: After testLine drops, a held no-bubble classification enters the pass state (passOk = 1). If the bubble classification persists for TIMEOUT_MS ticks, the block enters the failed state instead.
- R7: In the pass state, a held bubble classification sets safeTrip at the next edge. safeTrip stays 1 after the bubble clears, and passOk stays 1.
- R8: In the failed state, failSt = 1, safeTrip = 1 (set at the same edge as failSt), and testLine = 0. At most one of testLine, passOk and failSt is 1 at any time.
- R9: An edge that samples enable low returns the block to idle. testLine, passOk and failSt are 0 after that edge, and safeTrip keeps its value.
- R10: safeTrip is cleared only by reset or by entry into the pass state after a new self-test.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Supervisor enable; a rising level starts a self-test |
| msTick | input | 1 | One-clock pulse every millisecond |
| clsValid | input | 1 | Classifier result strobe |
| clsBubble | input | 1 | Classifier bubble flag, taken when clsValid is 1 |
| testLine | output | 1 | Drive to the sensor's test input |
| passOk | output | 1 | Self-test passed, monitoring active |
| failSt | output | 1 | Self-test failed |
| safeTrip | output | 1 | Latched safe-state request to the host device |

## Verification
The main sequence is run in four forms, and each separates a different branch of the control:
- A clean pass, where the bubble appears and then clears. This checks the exit of each phase.
- A force phase with no bubble ever reported. This separates the first timeout from a pass.
- A release phase where the bubble never clears. This isolates the second timeout.
- A pass followed by a monitored bubble. This shows that the trip latches and that only a new pass clears it.

Bubble levels presented without a strobe, and an enable that is high out of reset, show which inputs must be ignored.

// File: rtl/bubble_guard_pkg.sv
package bubble_guard_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FORCE   = 3'd1,
    ST_RELEASE = 3'd2,
    ST_ARMED   = 3'd3,
    ST_FAILED  = 3'd4
  } guardState_t;

  typedef struct packed {
    logic loadTimer;
    logic setSafe;
    logic clrSafe;
  } guardCmd_t;

endpackage

// File: rtl/bubble_guard_dp.sv
module bubble_guard_dp
  import bubble_guard_pkg::*;
#(
  parameter int TIMEOUT_MS = 500
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      msTick,
  input  logic      clsValid,
  input  logic      clsBubble,
  input  guardCmd_t cmd,
  output logic      enRise,
  output logic      heldBubble,
  output logic      timerDone,
  output logic      safeTrip
);
  localparam int CNT_W = $clog2(TIMEOUT_MS + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMEOUT_MS);

  logic             enPrev;
  logic [CNT_W-1:0] msLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev     <= 1'b1;
      heldBubble <= 1'b0;
    end else begin
      enPrev <= enable;
      if (clsValid) heldBubble <= clsBubble;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msLeft <= '0;
    end else if (cmd.loadTimer) begin
      msLeft <= LOAD_VAL;
    end else if (msTick && (msLeft != '0)) begin
      msLeft <= msLeft - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      safeTrip <= 1'b0;
    end else if (cmd.setSafe) begin
      safeTrip <= 1'b1;
    end else if (cmd.clrSafe) begin
      safeTrip <= 1'b0;
    end
  end

  assign enRise    = enable && !enPrev;
  assign timerDone = (msLeft == '0);

  AST_HELD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !clsValid |=> heldBubble == $past(heldBubble)); // R3

  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (msLeft == '0) && !cmd.loadTimer |=> msLeft == '0); // R5

  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    safeTrip && !cmd.clrSafe |=> safeTrip); // R10

endmodule

// File: rtl/bubble_guard_ctrl.sv
module bubble_guard_ctrl
  import bubble_guard_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      enRise,
  input  logic      heldBubble,
  input  logic      timerDone,
  output guardCmd_t cmd,
  output logic      testLine,
  output logic      passOk,
  output logic      failSt
);
  guardState_t curState, nxtState;

  always_comb begin
    nxtState      = curState;
    cmd.loadTimer = 1'b0;
    cmd.setSafe   = 1'b0;
    cmd.clrSafe   = 1'b0;
    if (!enable) begin
      nxtState = ST_IDLE;
    end else begin
      unique case (curState)
        ST_IDLE: if (enRise) begin
          nxtState      = ST_FORCE;
          cmd.loadTimer = 1'b1;
        end
        ST_FORCE: if (heldBubble) begin
          nxtState      = ST_RELEASE;
          cmd.loadTimer = 1'b1;
        end else if (timerDone) begin
          nxtState = ST_FAILED;
        end
        ST_RELEASE: if (!heldBubble) begin
          nxtState    = ST_ARMED;
          cmd.clrSafe = 1'b1;
        end else if (timerDone) begin
          nxtState = ST_FAILED;
        end
        ST_ARMED: if (heldBubble) cmd.setSafe = 1'b1;
        ST_FAILED: ;
        default: nxtState = ST_IDLE;
      endcase
      if (nxtState == ST_FAILED) cmd.setSafe = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

  assign testLine = (curState == ST_FORCE);
  assign passOk   = (curState == ST_ARMED);
  assign failSt   = (curState == ST_FAILED);

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({testLine, passOk, failSt})); // R8

  AST_EN_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !testLine && !passOk && !failSt); // R9

  AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !testLine && !(enable && !$past(enable)) |=> !testLine || $past(testLine) || $past(enRise)); // R2

  AST_FORCE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    testLine && heldBubble && enable |=> !testLine && !failSt); // R4

endmodule

// File: rtl/bubble_guard_top.sv
module bubble_guard_top
  import bubble_guard_pkg::*;
#(
  parameter int TIMEOUT_MS = 500
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic msTick,
  input  logic clsValid,
  input  logic clsBubble,
  output logic testLine,
  output logic passOk,
  output logic failSt,
  output logic safeTrip
);
  guardCmd_t cmd;
  logic      enRise;
  logic      heldBubble;
  logic      timerDone;

  bubble_guard_dp #(.TIMEOUT_MS(TIMEOUT_MS)) dp_i (
    .clk(clk), .rstN(rstN), .enable(enable), .msTick(msTick),
    .clsValid(clsValid), .clsBubble(clsBubble), .cmd(cmd),
    .enRise(enRise), .heldBubble(heldBubble), .timerDone(timerDone),
    .safeTrip(safeTrip)
  );

  bubble_guard_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .enRise(enRise),
    .heldBubble(heldBubble), .timerDone(timerDone), .cmd(cmd),
    .testLine(testLine), .passOk(passOk), .failSt(failSt)
  );

  AST_FAIL_TRIPS: assert property (@(posedge clk) disable iff (!rstN)
    failSt |-> safeTrip && !testLine); // R8

endmodule

// File: tb/bubble_guard_top_tb_top.sv
`timescale 1ns/1ps
module bubble_guard_top_tb_top;
  localparam int LIMIT   = 500;
  localparam int TICKDIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b1;
  logic msTick = 1'b0;
  logic clsValid = 1'b0;
  logic clsBubble = 1'b0;
  logic testLine, passOk, failSt, safeTrip;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  int tickPhase = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bubble_guard_top #(.TIMEOUT_MS(LIMIT)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .msTick(msTick),
    .clsValid(clsValid), .clsBubble(clsBubble), .testLine(testLine),
    .passOk(passOk), .failSt(failSt), .safeTrip(safeTrip)
  );

  // reference model: 0 idle, 1 test driven, 2 test released, 3 monitoring, 4 failed
  int  mMode = 0;
  int  mLeft = 0;
  bit  mSeen = 0;
  bit  mLastEn = 1;
  bit  mTrip = 0;

  always @(posedge clk) begin
    int  nMode;
    bit  trip, untrip, reload;
    if (!rstN) begin
      mMode = 0; mLeft = 0; mSeen = 0; mLastEn = 1; mTrip = 0;
    end else begin
      nMode = mMode; trip = 0; untrip = 0; reload = 0;
      if (!enable) nMode = 0;
      else if (mMode == 0 && !mLastEn) begin nMode = 1; reload = 1; end
      else if (mMode == 1) begin
        if (mSeen) begin nMode = 2; reload = 1; end
        else if (mLeft == 0) nMode = 4;
      end else if (mMode == 2) begin
        if (!mSeen) begin nMode = 3; untrip = 1; end
        else if (mLeft == 0) nMode = 4;
      end else if (mMode == 3 && mSeen) trip = 1;
      if (enable && nMode == 4) trip = 1;
      if (reload) mLeft = LIMIT;
      else if (msTick && mLeft > 0) mLeft = mLeft - 1;
      if (trip) mTrip = 1;
      else if (untrip) mTrip = 0;
      if (clsValid) mSeen = clsBubble;
      mLastEn = enable;
      mMode = nMode;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cmpOn) begin
      check("R2 testLine vs model", testLine, mMode == 1);
      check("R6 passOk vs model",   passOk,   mMode == 3);
      check("R8 failSt vs model",   failSt,   mMode == 4);
      check("R7 safeTrip vs model", safeTrip, mTrip);
    end
    tickPhase = (tickPhase + 1) % TICKDIV;
    msTick = (tickPhase == 0);
    if (cycles > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendCls(input logic b);
    @(negedge clk);
    clsValid = 1'b1; clsBubble = b;
    @(negedge clk);
    clsValid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    waitCyc(2);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    cmpOn = 1'b1;
    waitCyc(5);
    // R1: enable high out of reset starts nothing
    check("R1 testLine idle", testLine, 1'b0);
    check("R1 passOk idle",   passOk,   1'b0);
    check("R1 failSt idle",   failSt,   1'b0);
    check("R1 safeTrip idle", safeTrip, 1'b0);

    // clean pass
    restart();
    check("R2 testLine after rise", testLine, 1'b1);
    @(negedge clk); clsBubble = 1'b1;          // no strobe: ignored
    waitCyc(6);
    check("R3 unstrobed bubble ignored", testLine, 1'b1);
    clsBubble = 1'b0;
    sendCls(1'b1);
    waitCyc(2);
    check("R4 testLine released", testLine, 1'b0);
    check("R4 not failed", failSt, 1'b0);
    sendCls(1'b0);
    waitCyc(2);
    check("R6 passOk after clear", passOk, 1'b1);
    check("R10 safeTrip clear on pass", safeTrip, 1'b0);

    // monitored bubble
    sendCls(1'b1);
    waitCyc(2);
    check("R7 safeTrip on bubble", safeTrip, 1'b1);
    sendCls(1'b0);
    waitCyc(3);
    check("R7 safeTrip stays latched", safeTrip, 1'b1);
    check("R7 passOk stays", passOk, 1'b1);

    // disable
    @(negedge clk); enable = 1'b0;
    waitCyc(2);
    check("R9 passOk cleared", passOk, 1'b0);
    check("R9 safeTrip kept", safeTrip, 1'b1);
    check("R10 safeTrip kept while idle", safeTrip, 1'b1);

    // new pass clears trip
    @(negedge clk); enable = 1'b1;
    waitCyc(2);
    sendCls(1'b1);
    waitCyc(2);
    sendCls(1'b0);
    waitCyc(2);
    check("R10 new pass clears trip", safeTrip, 1'b0);

    // force-phase timeout
    restart();
    check("R5 test line up", testLine, 1'b1);
    waitCyc(LIMIT * TICKDIV / 2);
    check("R5 not yet expired", failSt, 1'b0);
    waitCyc(LIMIT * TICKDIV / 2 + 3 * TICKDIV);
    check("R5 failed after timeout", failSt, 1'b1);
    check("R8 trip on failure", safeTrip, 1'b1);
    check("R8 test line low on failure", testLine, 1'b0);

    // release-phase timeout
    restart();
    check("R9 fail status cleared by restart", failSt, 1'b0);
    sendCls(1'b1);
    waitCyc(2);
    check("R6 in release phase", testLine, 1'b0);
    waitCyc(LIMIT * TICKDIV + 3 * TICKDIV);
    check("R6 release timeout fails", failSt, 1'b1);
    check("R6 no pass", passOk, 1'b0);
    sendCls(1'b0);
    waitCyc(2);
    check("R8 failure holds", failSt, 1'b1);

    // reset clears the trip
    @(negedge clk); rstN = 1'b0;
    waitCyc(2);
    rstN = 1'b1;
    waitCyc(2);
    check("R1 trip cleared by reset", safeTrip, 1'b0);
    check("R1 no test after reset", testLine, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule